// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents the most urgent one to a processor as a priority level and a vector number. Each source has a software-programmable level byte. A source takes part only while that byte is nonzero, while its request line or its software force bit is set, and while its mask bit is clear.

Software reaches the block through a simple register bus over a 256-byte window. The 64-bit pending, mask and force registers are read and written as two 32-bit words. The per-source level bytes are accessed one byte at a time. A software-acknowledge location returns the vector currently presented. Reads complete combinationally in the cycle of the access and writes take effect at the next clock edge. Accesses to undecoded locations, and to the unsupported per-level hardware acknowledge locations, return an error flag.

The winner is the active source with the highest level. Among equal levels the higher source number wins. The vector is the winner's number plus 64, and it falls back to 24 with level 0 when nothing is active.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending register copies `irq_in` at every rising clock edge. Bit n holds while line n was high at the last edge and clears while it was low. It reads as its upper half at offset 0x00 and its lower half at offset 0x04.
- R2: Source n is active exactly when (pending[n] OR force[n]) AND enabled[n] AND NOT mask[n] holds. The force register reads and writes as its upper half at 0x10 and its lower half at 0x14.
- R3: Among the active sources the one with the largest level byte wins. When levels are equal, the higher source number wins.
- R4: `irq_vector` is 64 plus the winning source number and `irq_level` is its level byte. With no active source, `irq_level` is 0 and `irq_vector` is 24.
- R5: The level byte of source n sits at offset 0x40+n and reads back in `bus_rdata[7:0]` with the upper bits zero. A write of zero clears the source's enabled bit and a nonzero write sets it.
- R6: Writes to 0x00 and 0x04 are accepted without error and leave the pending register unchanged.
- R7: The mask register is written as its upper half at 0x08 (sources 63..32) and its lower half at 0x0C (sources 31..0). Each write leaves the other half unchanged. Bit 8 of the upper word is source 40.
- R8: A read of offset 0xE0 returns the vector currently driven on `irq_vector` in `bus_rdata[7:0]`.
- R9: `bus_err` is raised for any access to 0xE1..0xE7, for a write to 0xE0, and for any access to an offset that is not decoded (for example 0x20). Decoded accesses leave it low.
- R10: Reset clears the pending and force registers, the enabled bits and every level byte, sets all mask bits, and drives level 0 and vector 24.
- R11: The outputs are registered. A change of register state appears on `irq_level`/`irq_vector` one clock edge later, so a request line that rises before edge k shows on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data (level bytes use bits 7:0) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for the current access |
| irq_level | output | 8 | Level of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector of the winning source, 24 when idle |

## Verification
The hardest situation to reach is a tie between equal levels where the lower-numbered source would win under a first-found rule. Reaching it needs two sources with identical level bytes active together, with both orders of programming. The stimulus table programs matching levels on sources 10 and 20, and on 0 and 63, then raises both lines of each pair at once. It also mixes sources that are disabled, masked or only forced, so that each term of the active condition on its own decides the winner.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
// irq_prio_pkg: shared sizes and register offsets of the interrupt controller.
// Assumes an 8-bit byte offset bus and a level-byte block aligned to its size.
package irq_prio_pkg;
    localparam int unsigned NSRC_DEF = 64;
    localparam int unsigned LVLW_DEF = 8;
    localparam int unsigned VECW_DEF = 8;
    localparam int unsigned DW_DEF   = 32;
    localparam int unsigned AW_DEF   = 8;

    localparam logic [7:0] VEC_SPURIOUS = 8'd24;
    localparam logic [7:0] VEC_BASE     = 8'd64;

    localparam logic [7:0] OFS_PEND_HI  = 8'h00;
    localparam logic [7:0] OFS_PEND_LO  = 8'h04;
    localparam logic [7:0] OFS_MASK_HI  = 8'h08;
    localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
    localparam logic [7:0] OFS_FRC_HI   = 8'h10;
    localparam logic [7:0] OFS_FRC_LO   = 8'h14;
    localparam logic [7:0] OFS_LVL_BASE = 8'h40;
    localparam logic [7:0] OFS_SWACK    = 8'hE0;
    localparam logic [7:0] OFS_LACK_LO  = 8'hE1;
    localparam logic [7:0] OFS_LACK_HI  = 8'hE7;
endpackage

// File: rtl/irq_regfile.sv
`timescale 1ns/1ps
// irq_regfile: register storage and bus decode of the interrupt controller.
// Holds pending (sampled from the lines), mask, force, enabled bits and one
// level byte per source. Reads are combinational; writes land on the clock.
// Assumes NSRC == 2*DW and the level-byte block aligned to NSRC bytes.
module irq_regfile #(
    parameter int unsigned NSRC = irq_prio_pkg::NSRC_DEF,
    parameter int unsigned LVLW = irq_prio_pkg::LVLW_DEF,
    parameter int unsigned VECW = irq_prio_pkg::VECW_DEF,
    parameter int unsigned DW   = irq_prio_pkg::DW_DEF,
    parameter int unsigned AW   = irq_prio_pkg::AW_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           irq_in,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [AW-1:0]             bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic                      bus_err,
    input  logic [VECW-1:0]           cur_vec,
    output logic [NSRC-1:0]           pend_o,
    output logic [NSRC-1:0]           mask_o,
    output logic [NSRC-1:0]           frc_o,
    output logic [NSRC-1:0]           en_o,
    output logic [NSRC-1:0][LVLW-1:0] lvl_o
);
    import irq_prio_pkg::*;

    localparam int unsigned HALF = NSRC / 2;
    localparam int unsigned IDXW = $clog2(NSRC);
    localparam int unsigned LVL_END = int'(OFS_LVL_BASE) + NSRC;

    logic [NSRC-1:0]           pend_q, mask_q, frc_q, en_q;
    logic [NSRC-1:0][LVLW-1:0] lvl_q;
    logic                      lvl_hit;
    logic [IDXW-1:0]           lvl_idx;

    // Decode whether the access falls inside the level-byte block.
    always_comb begin
        lvl_hit = (int'(bus_addr) >= int'(OFS_LVL_BASE)) && (int'(bus_addr) < LVL_END);
        lvl_idx = bus_addr[IDXW-1:0];
    end

    // Read mux and error decode for the current access.
    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        if (bus_sel) begin
            if (lvl_hit) begin
                bus_rdata = {{(DW-LVLW){1'b0}}, lvl_q[lvl_idx]};
            end else begin
                case (bus_addr)
                    OFS_PEND_HI: bus_rdata = pend_q[NSRC-1:HALF];
                    OFS_PEND_LO: bus_rdata = pend_q[HALF-1:0];
                    OFS_MASK_HI: bus_rdata = mask_q[NSRC-1:HALF];
                    OFS_MASK_LO: bus_rdata = mask_q[HALF-1:0];
                    OFS_FRC_HI:  bus_rdata = frc_q[NSRC-1:HALF];
                    OFS_FRC_LO:  bus_rdata = frc_q[HALF-1:0];
                    OFS_SWACK: begin
                        if (bus_wr) bus_err = 1'b1;
                        else        bus_rdata = {{(DW-VECW){1'b0}}, cur_vec};
                    end
                    default:     bus_err = 1'b1;
                endcase
            end
        end
    end

    // Register updates: line sampling every cycle, software writes on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '1;
            frc_q  <= '0;
            en_q   <= '0;
            lvl_q  <= '0;
        end else begin
            pend_q <= irq_in;
            if (bus_sel && bus_wr) begin
                if (lvl_hit) begin
                    lvl_q[lvl_idx] <= bus_wdata[LVLW-1:0];
                    en_q[lvl_idx]  <= |bus_wdata[LVLW-1:0];
                end else begin
                    case (bus_addr)
                        OFS_MASK_HI: mask_q[NSRC-1:HALF] <= bus_wdata;
                        OFS_MASK_LO: mask_q[HALF-1:0]    <= bus_wdata;
                        OFS_FRC_HI:  frc_q[NSRC-1:HALF]  <= bus_wdata;
                        OFS_FRC_LO:  frc_q[HALF-1:0]     <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign frc_o  = frc_q;
    assign en_o   = en_q;
    assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_prio_search.sv
`timescale 1ns/1ps
// irq_prio_search: combinational winner search over the active sources.
// Scans upward from source 0; a later source replaces the best on a level
// greater than or equal to it, so ties go to the higher number.
// Assumes an active source always has a nonzero level byte.
module irq_prio_search #(
    parameter int unsigned NSRC = irq_prio_pkg::NSRC_DEF,
    parameter int unsigned LVLW = irq_prio_pkg::LVLW_DEF,
    parameter int unsigned VECW = irq_prio_pkg::VECW_DEF
) (
    input  logic [NSRC-1:0]           active,
    input  logic [NSRC-1:0][LVLW-1:0] lvl,
    output logic [LVLW-1:0]           win_lvl,
    output logic [VECW-1:0]           win_vec
);
    import irq_prio_pkg::*;

    localparam int unsigned IDXW = $clog2(NSRC);

    logic [LVLW-1:0] best_lvl;
    logic [IDXW-1:0] best_idx;
    logic            found;

    // Linear scan picking the highest level, last one found on ties.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (active[i] && (lvl[i] >= best_lvl)) begin
                best_lvl = lvl[i];
                best_idx = IDXW'(i);
                found    = 1'b1;
            end
        end
        win_lvl = found ? best_lvl : '0;
        win_vec = found ? (VECW'(VEC_BASE) + VECW'(best_idx)) : VECW'(VEC_SPURIOUS);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
// irq_prio_ctrl: top of the prioritized interrupt controller.
// Combines pending, force, enabled and mask into the active set, finds the
// winner and registers level and vector toward the processor.
// Assumes a synchronous active-low reset and single-cycle bus accesses.
module irq_prio_ctrl #(
    parameter int unsigned NSRC = irq_prio_pkg::NSRC_DEF,
    parameter int unsigned LVLW = irq_prio_pkg::LVLW_DEF,
    parameter int unsigned VECW = irq_prio_pkg::VECW_DEF,
    parameter int unsigned DW   = irq_prio_pkg::DW_DEF,
    parameter int unsigned AW   = irq_prio_pkg::AW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_err,
    output logic [LVLW-1:0] irq_level,
    output logic [VECW-1:0] irq_vector
);
    import irq_prio_pkg::*;

    logic [NSRC-1:0]           pend_q, mask_q, frc_q, en_q, act;
    logic [NSRC-1:0][LVLW-1:0] lvl_q;
    logic [LVLW-1:0]           win_lvl;
    logic [VECW-1:0]           win_vec;

    irq_regfile #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .cur_vec   (irq_vector),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .frc_o     (frc_q),
        .en_o      (en_q),
        .lvl_o     (lvl_q)
    );

    // Active set: requested or forced, enabled, and not masked.
    assign act = (pend_q | frc_q) & en_q & ~mask_q;

    irq_prio_search #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW)) u_search (
        .active  (act),
        .lvl     (lvl_q),
        .win_lvl (win_lvl),
        .win_vec (win_vec)
    );

    // Output register toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= VECW'(VEC_SPURIOUS);
        end else begin
            irq_level  <= win_lvl;
            irq_vector <= win_vec;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
// irq_prio_ctrl_chk: property checker bound to irq_prio_ctrl.
// Observes ports and the register state that the register file drives.
module irq_prio_ctrl_chk #(
    parameter int unsigned NSRC = irq_prio_pkg::NSRC_DEF,
    parameter int unsigned LVLW = irq_prio_pkg::LVLW_DEF,
    parameter int unsigned VECW = irq_prio_pkg::VECW_DEF,
    parameter int unsigned AW   = irq_prio_pkg::AW_DEF
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NSRC-1:0]           irq_in,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [AW-1:0]             bus_addr,
    input logic                      bus_err,
    input logic [LVLW-1:0]           irq_level,
    input logic [VECW-1:0]           irq_vector,
    input logic [NSRC-1:0]           pend,
    input logic [NSRC-1:0]           mask,
    input logic [NSRC-1:0]           frc,
    input logic [NSRC-1:0]           en,
    input logic [NSRC-1:0][LVLW-1:0] lvl
);
    import irq_prio_pkg::*;

    localparam int unsigned HALF = NSRC / 2;

    logic [NSRC-1:0] chk_act, lvl_nz;

    // Independent view of the active set and of nonzero level bytes.
    always_comb begin
        chk_act = (pend | frc) & en & ~mask;
        for (int i = 0; i < int'(NSRC); i++) lvl_nz[i] = |lvl[i];
    end

    AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(irq_in)); // R1
    AST_ACTIVE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|chk_act) |=> (irq_level != '0)); // R2
    AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|chk_act) |=> (irq_level == '0) && (irq_vector == VECW'(VEC_SPURIOUS))); // R4
    AST_LEVEL_VECTOR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) == (irq_vector == VECW'(VEC_SPURIOUS))); // R4
    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_vector >= VECW'(VEC_BASE)) &&
                              (int'(irq_vector) < int'(VEC_BASE) + int'(NSRC))); // R4
    AST_ENABLE_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        en == lvl_nz); // R5
    AST_MASK_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(OFS_MASK_HI))
        |=> mask[HALF-1:0] == $past(mask[HALF-1:0])); // R7
    AST_MASK_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(OFS_MASK_LO))
        |=> mask[NSRC-1:HALF] == $past(mask[NSRC-1:HALF])); // R7
    AST_LEVEL_ACK_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr >= AW'(OFS_LACK_LO) && bus_addr <= AW'(OFS_LACK_HI))
        |-> bus_err); // R9
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_level == '0) && (irq_vector == VECW'(VEC_SPURIOUS))); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_err    (bus_err),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .pend       (pend_q),
    .mask       (mask_q),
    .frc        (frc_q),
    .en         (en_q),
    .lvl        (lvl_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
// irq_prio_ctrl_bench: table-driven plus directed bench for irq_prio_ctrl.
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    // Table: request lines, expected level, expected vector.
    // Levels: src0=1, src3=2, src10=5, src20=5, src40=7, src63=1, src5 unprogrammed.
    localparam int NVEC = 9;
    localparam logic [79:0] STIM [NVEC] = '{
        {64'h0000_0000_0000_0000, 8'd0, 8'd24},
        {64'h0000_0000_0000_0008, 8'd2, 8'd67},
        {64'h0000_0000_0000_0408, 8'd5, 8'd74},
        {64'h0000_0000_0010_0400, 8'd5, 8'd84},
        {64'h0000_0100_0010_0000, 8'd7, 8'd104},
        {64'h8000_0000_0000_0001, 8'd1, 8'd127},
        {64'h0000_0000_0000_0001, 8'd1, 8'd64},
        {64'h0000_0000_0000_0020, 8'd0, 8'd24},
        {64'h8000_0000_0000_0008, 8'd2, 8'd67}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1 e = bus_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata; e = bus_err;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        logic [31:0] rd;
        logic e;
        do_reset();
        // R10: reset state
        chk("R10 level", irq_level, 0);
        chk("R10 vector", irq_vector, 24);
        bus_read(8'h08, rd, e); chk("R10 mask hi", rd, 32'hFFFF_FFFF);
        bus_read(8'h0C, rd, e); chk("R10 mask lo", rd, 32'hFFFF_FFFF);
        bus_read(8'h43, rd, e); chk("R10 level byte", rd, 0);
        bus_read(8'h14, rd, e); chk("R10 force lo", rd, 0);
        bus_read(8'h04, rd, e); chk("R10 pending lo", rd, 0);

        // Program levels and unmask everything (R5, R7).
        bus_write(8'h40, 32'd1, e); chk("R5 write err", e, 0);
        bus_write(8'h43, 32'd2, e);
        bus_write(8'h4A, 32'd5, e);
        bus_write(8'h54, 32'd5, e);
        bus_write(8'h68, 32'd7, e);
        bus_write(8'h7F, 32'd1, e);
        bus_write(8'h08, 32'd0, e); chk("R7 write err", e, 0);
        bus_write(8'h0C, 32'd0, e);
        bus_read(8'h4A, rd, e); chk("R5 level byte readback", rd, 5);

        // R3/R4: table of request patterns.
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk); irq_in = STIM[k][79:16];
            settle();
            chk($sformatf("R3 level vec%0d", k), irq_level, STIM[k][15:8]);
            chk($sformatf("R4 vector vec%0d", k), irq_vector, STIM[k][7:0]);
        end

        // R1: pending follows lines.
        @(negedge clk); irq_in = 64'h8000_0000_0000_0008;
        settle();
        bus_read(8'h00, rd, e); chk("R1 pending hi", rd, 32'h8000_0000);
        bus_read(8'h04, rd, e); chk("R1 pending lo", rd, 32'h0000_0008);

        // R7: mask upper half alone, source 40 masked.
        @(negedge clk); irq_in = 64'h0000_0100_0010_0000;
        settle();
        chk("R7 before mask", irq_vector, 104);
        bus_write(8'h08, 32'h0000_0100, e);
        settle();
        chk("R7 masked winner", irq_vector, 84);
        bus_read(8'h0C, rd, e); chk("R7 lower half kept", rd, 0);
        bus_write(8'h0C, 32'h0000_0001, e);
        bus_read(8'h08, rd, e); chk("R7 upper half kept", rd, 32'h0000_0100);
        bus_write(8'h0C, 32'h0, e);
        bus_write(8'h08, 32'h0, e);

        // R2: force alone makes a source active.
        @(negedge clk); irq_in = '0;
        bus_write(8'h14, 32'h0000_0008, e);
        settle();
        chk("R2 forced lo level", irq_level, 2);
        chk("R2 forced lo vector", irq_vector, 67);
        bus_read(8'h14, rd, e); chk("R2 force readback", rd, 8);
        bus_write(8'h14, 32'h0, e);
        bus_write(8'h10, 32'h8000_0000, e);
        settle();
        chk("R2 forced hi vector", irq_vector, 127);
        bus_write(8'h0C, 32'h0000_0000, e);
        bus_write(8'h08, 32'h8000_0000, e);
        settle();
        chk("R2 forced but masked", irq_vector, 24);
        bus_write(8'h08, 32'h0, e);
        bus_write(8'h10, 32'h0, e);

        // R5: zero level disables the source.
        bus_write(8'h4A, 32'd0, e);
        @(negedge clk); irq_in = 64'h0000_0000_0000_0400;
        settle();
        chk("R5 disabled level", irq_level, 0);
        chk("R5 disabled vector", irq_vector, 24);
        bus_read(8'h4A, rd, e); chk("R5 cleared byte", rd, 0);
        bus_write(8'h4A, 32'hFFFF_FF09, e);
        settle();
        chk("R5 re-enabled vector", irq_vector, 74);
        bus_read(8'h4A, rd, e); chk("R5 byte only", rd, 9);

        // R6: pending ignores writes.
        @(negedge clk); irq_in = 64'h0000_0000_0000_0020;
        settle();
        bus_write(8'h04, 32'hFFFF_FFFF, e); chk("R6 no error", e, 0);
        bus_write(8'h00, 32'hFFFF_FFFF, e);
        bus_read(8'h04, rd, e); chk("R6 pending lo kept", rd, 32'h20);
        bus_read(8'h00, rd, e); chk("R6 pending hi kept", rd, 0);
        chk("R6 output idle", irq_vector, 24);

        // R11 then R8: latency and software acknowledge.
        @(negedge clk); irq_in = '0;
        settle();
        @(negedge clk); irq_in = 64'h0000_0000_0000_0008;
        @(negedge clk);
        chk("R11 one edge later", irq_level, 0);
        @(negedge clk);
        chk("R11 two edges later", irq_level, 2);
        bus_read(8'hE0, rd, e);
        chk("R8 ack vector", rd, 67);
        chk("R8 ack no error", e, 0);

        // R9: error responses.
        bus_read(8'hE3, rd, e); chk("R9 read E3", e, 1);
        bus_write(8'hE7, 32'h1, e); chk("R9 write E7", e, 1);
        bus_read(8'hE1, rd, e); chk("R9 read E1", e, 1);
        bus_read(8'h20, rd, e); chk("R9 read 20", e, 1);
        bus_write(8'hE0, 32'h1, e); chk("R9 write E0", e, 1);
        bus_read(8'h08, rd, e); chk("R9 decoded ok", e, 0);

        // R10: reset mid-run with a request held.
        bus_write(8'h0C, 32'h1234_5678, e);
        do_reset();
        chk("R10 rerun level", irq_level, 0);
        chk("R10 rerun vector", irq_vector, 24);
        bus_read(8'h0C, rd, e); chk("R10 rerun mask lo", rd, 32'hFFFF_FFFF);
        bus_read(8'h43, rd, e); chk("R10 rerun level byte", rd, 0);
        settle();
        chk("R10 held line ignored", irq_vector, 24);
        bus_read(8'hE0, rd, e); chk("R10 ack spurious", rd, 24);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule